// File: doc/BRIEF.md
# Frame-Gated Synchronous Serial Transmitter

One transmit channel of a frame-based synchronous serial port. Software writes words into a holding register. On a frame sync the channel copies the held word into a shift register. It then sends the word MSB first on `sd_o`, one bit per clock. A transmit-enable bit decides whether a frame carries data. The bit is read only when a frame sync arrives, so writing it mid-frame changes nothing until the next frame begins.

Clearing the enable does not cut off a word that is already being shifted. The word completes, and the pin then goes to high impedance. Any word still waiting in the holding register is thrown away. If a whole frame starts with the enable clear, the pin is not left floating. It is driven from a registered copy of `flag_i` for that frame and serves as a general-purpose output flag.

In network mode, several words follow each other inside one frame. A clear of the enable, even if it is set again at once, stops the channel after the current word until the next frame sync. When the holding register is empty at a transfer point, the previous word is sent again and an underrun status is raised.

Top module: `fgs_tx`

## Requirements
- R1: On a clock edge with `fs_i` high and the enable set, the held word is loaded. From that edge on, `sd_oe_o` is 1 and `sd_o` carries bit W-1 first, then one lower bit after each following edge, for W bits.
- R2: A write to the enable (`ctrl_wr_i` with `ctrl_en_i`) between frame syncs leaves the pin behaviour of the current frame unchanged. It applies from the next `fs_i`.
- R3: Clearing the enable (`ctrl_wr_i`=1, `ctrl_en_i`=0) in the middle of a word lets that word finish. After it, `sd_oe_o` stays 0 for the rest of the frame.
- R4: Clearing the enable while it is set discards the held word. `empty_o` is 1 after that edge, and the discarded word is never sent.
- R5: A write (`wr_i`) while the enable is clear makes `empty_o` 0 after the edge. No transfer takes place: the pin keeps its idle or flag behaviour until an enabled frame sync.
- R6: If the enable is clear at `fs_i`, then for that whole frame `sd_oe_o`=1 and `sd_o` equals `flag_i` as sampled on the previous edge.
- R7: With `net_mode_i`=1 and the channel active, the next word is loaded at the edge that follows a word's last bit, with no gap. If the enable was cleared during the frame, even if it was set again, the channel stops after the current word (`sd_oe_o`=0) until the next `fs_i`.
- R8: Hardware reset and a `soft_rst_i` pulse both clear the enable. After hardware reset, `sd_oe_o`=0, `empty_o`=1 and `underrun_o`=0. After a soft reset, the current word finishes and the next frame is a flag frame.
- R9: Every load sets `empty_o`. A load with the holding register empty resends the last word and sets `underrun_o`. The next write clears `underrun_o`.
- R10: With `net_mode_i`=0, only one word is sent per frame. At the edge after its last bit, `sd_oe_o` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Software reset pulse, clears the enable |
| ctrl_wr_i | input | 1 | Write strobe for the enable bit |
| ctrl_en_i | input | 1 | Value written to the enable bit |
| net_mode_i | input | 1 | 1: many words per frame, 0: one word per frame |
| fs_i | input | 1 | Frame sync pulse |
| wr_i | input | 1 | Holding register write strobe |
| wr_data_i | input | W | Word to transmit |
| flag_i | input | 1 | Level driven on the pin in flag frames |
| sd_o | output | 1 | Serial data |
| sd_oe_o | output | 1 | Output enable for the pin driver |
| empty_o | output | 1 | Holding register empty |
| underrun_o | output | 1 | A word was resent because the holding register was empty |

## Verification
Every result is registered once, so it is due on the edge that takes the stimulus. A word's MSB appears just after the frame sync edge, and bit W-1-k after the k-th following edge. The empty and underrun flags change on the edge of the write, load or enable clear. The flag pin follows `flag_i` one edge late. The bench drives inputs and samples outputs 1 ns after each rising edge. It steps one edge per expected bit, so every comparison reads the value that the last edge produced.

// File: rtl/fgs_tx_pkg.sv
package fgs_tx_pkg;
  typedef enum logic [1:0] {
    LINE_HIZ  = 2'd0,
    LINE_DATA = 2'd1,
    LINE_FLAG = 2'd2
  } line_sel_e;
endpackage

// File: rtl/fgs_tx_ctrl.sv
module fgs_tx_ctrl
  import fgs_tx_pkg::*;
#(
  parameter int unsigned W = 24
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      soft_rst_i,
  input  logic      ctrl_wr_i,
  input  logic      ctrl_en_i,
  input  logic      net_mode_i,
  input  logic      fs_i,
  output logic      en_o,
  output logic      active_o,
  output logic      flag_mode_o,
  output logic      load_o,
  output logic      disc_o,
  output line_sel_e line_o
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(W - 1);

  logic          en_q, drop_q, active_q, flag_mode_q;
  logic [CW-1:0] cnt_q;
  logic          word_end, cont, load_fs, load_nx, disc;

  assign word_end = active_q && (cnt_q == LAST_BIT);
  // any clear of a set enable, by register write or soft reset
  assign disc     = en_q && (soft_rst_i || (ctrl_wr_i && !ctrl_en_i));
  assign cont     = net_mode_i && en_q && !drop_q && !disc;
  assign load_fs  = fs_i && en_q;
  assign load_nx  = !fs_i && word_end && cont;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
    end else if (soft_rst_i) begin
      en_q <= 1'b0;
    end else if (ctrl_wr_i) begin
      en_q <= ctrl_en_i;
    end
  end

  // a clear during the frame blocks further words until the next sync
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drop_q <= 1'b0;
    end else if (fs_i) begin
      drop_q <= 1'b0;
    end else if (disc) begin
      drop_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= 1'b0;
      cnt_q       <= '0;
      flag_mode_q <= 1'b0;
    end else if (fs_i) begin
      active_q    <= en_q;
      cnt_q       <= '0;
      flag_mode_q <= !en_q;
    end else if (active_q) begin
      if (word_end) begin
        active_q <= cont;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    if (active_q) begin
      line_o = LINE_DATA;
    end else if (flag_mode_q) begin
      line_o = LINE_FLAG;
    end else begin
      line_o = LINE_HIZ;
    end
  end

  assign en_o        = en_q;
  assign active_o    = active_q;
  assign flag_mode_o = flag_mode_q;
  assign load_o      = load_fs || load_nx;
  assign disc_o      = disc;
endmodule

// File: rtl/fgs_tx_hold.sv
module fgs_tx_hold #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         load_i,
  input  logic         disc_i,
  output logic [W-1:0] src_o,
  output logic         empty_o,
  output logic         underrun_o
);
  logic [W-1:0] hold_q, last_q, src;
  logic         empty_q, underrun_q;

  // an empty holder makes the previous word go out again
  assign src = empty_q ? last_q : hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
    end else if (wr_i) begin
      hold_q <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
    end else if (load_i) begin
      last_q <= src;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_q    <= 1'b1;
      underrun_q <= 1'b0;
    end else if (wr_i) begin
      empty_q    <= 1'b0;
      underrun_q <= 1'b0;
    end else begin
      if (load_i || disc_i) begin
        empty_q <= 1'b1;
      end
      if (load_i && empty_q) begin
        underrun_q <= 1'b1;
      end
    end
  end

  assign src_o      = src;
  assign empty_o    = empty_q;
  assign underrun_o = underrun_q;
endmodule

// File: rtl/fgs_tx_shift.sv
module fgs_tx_shift
  import fgs_tx_pkg::*;
#(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         active_i,
  input  logic [W-1:0] src_i,
  input  logic         flag_i,
  input  line_sel_e    line_i,
  output logic         sd_o,
  output logic         sd_oe_o
);
  logic [W-1:0] sh_q;
  logic         flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
    end else if (load_i) begin
      sh_q <= src_i;
    end else if (active_i) begin
      sh_q <= {sh_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_i;
    end
  end

  always_comb begin
    unique case (line_i)
      LINE_DATA: begin
        sd_o    = sh_q[W-1];
        sd_oe_o = 1'b1;
      end
      LINE_FLAG: begin
        sd_o    = flag_q;
        sd_oe_o = 1'b1;
      end
      default: begin
        sd_o    = 1'b0;
        sd_oe_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/fgs_tx.sv
module fgs_tx
  import fgs_tx_pkg::*;
#(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         soft_rst_i,
  input  logic         ctrl_wr_i,
  input  logic         ctrl_en_i,
  input  logic         net_mode_i,
  input  logic         fs_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         flag_i,
  output logic         sd_o,
  output logic         sd_oe_o,
  output logic         empty_o,
  output logic         underrun_o
);
  logic         en_w, active_w, flag_mode_w, load_w, disc_w;
  logic [W-1:0] src_w;
  line_sel_e    line_w;

  fgs_tx_ctrl #(.W(W)) ctrl_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .ctrl_wr_i  (ctrl_wr_i),
    .ctrl_en_i  (ctrl_en_i),
    .net_mode_i (net_mode_i),
    .fs_i       (fs_i),
    .en_o       (en_w),
    .active_o   (active_w),
    .flag_mode_o(flag_mode_w),
    .load_o     (load_w),
    .disc_o     (disc_w),
    .line_o     (line_w)
  );

  fgs_tx_hold #(.W(W)) hold_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .load_i    (load_w),
    .disc_i    (disc_w),
    .src_o     (src_w),
    .empty_o   (empty_o),
    .underrun_o(underrun_o)
  );

  fgs_tx_shift #(.W(W)) shift_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_w),
    .active_i(active_w),
    .src_i   (src_w),
    .flag_i  (flag_i),
    .line_i  (line_w),
    .sd_o    (sd_o),
    .sd_oe_o (sd_oe_o)
  );
endmodule

// File: rtl/fgs_tx_chk.sv
module fgs_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic soft_rst_i,
  input logic ctrl_wr_i,
  input logic ctrl_en_i,
  input logic wr_i,
  input logic flag_i,
  input logic en_w,
  input logic active_w,
  input logic flag_mode_w,
  input logic load_w,
  input logic sd_o,
  input logic sd_oe_o,
  input logic empty_o,
  input logic underrun_o
);
  p_load_drives_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_w |=> sd_oe_o);

  p_clear_discards_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_w && ctrl_wr_i && !ctrl_en_i && !wr_i) |=> empty_o);

  p_write_fills_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (!empty_o && !underrun_o));

  p_flag_pin_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_mode_w && !active_w) |-> (sd_oe_o && (sd_o == $past(flag_i))));

  p_soft_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !en_w);

  p_load_empties_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_w && !wr_i) |=> empty_o);

  p_underrun_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_w && empty_o && !wr_i) |=> underrun_o);
endmodule

bind fgs_tx fgs_tx_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .soft_rst_i (soft_rst_i),
  .ctrl_wr_i  (ctrl_wr_i),
  .ctrl_en_i  (ctrl_en_i),
  .wr_i       (wr_i),
  .flag_i     (flag_i),
  .en_w       (en_w),
  .active_w   (active_w),
  .flag_mode_w(flag_mode_w),
  .load_w     (load_w),
  .sd_o       (sd_o),
  .sd_oe_o    (sd_oe_o),
  .empty_o    (empty_o),
  .underrun_o (underrun_o)
);

// File: tb/fgs_tx_tb_top.sv
module fgs_tx_tb_top;
  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         soft_rst_i = 1'b0, ctrl_wr_i = 1'b0, ctrl_en_i = 1'b0;
  logic         net_mode_i = 1'b0, fs_i = 1'b0, wr_i = 1'b0, flag_i = 1'b0;
  logic [W-1:0] wr_data_i = '0;
  logic         sd_o, sd_oe_o, empty_o, underrun_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  fgs_tx #(.W(W)) dut_i (
    .clk_i, .rst_ni, .soft_rst_i, .ctrl_wr_i, .ctrl_en_i, .net_mode_i,
    .fs_i, .wr_i, .wr_data_i, .flag_i, .sd_o, .sd_oe_o, .empty_o, .underrun_o
  );

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [W-1:0] v);
    wr_i = 1'b1; wr_data_i = v;
    step();
    wr_i = 1'b0;
  endtask

  task automatic set_en(input logic e);
    ctrl_wr_i = 1'b1; ctrl_en_i = e;
    step();
    ctrl_wr_i = 1'b0;
  endtask

  // one word on the pin; k=0 edge is the frame sync or the word boundary
  task automatic word_bits(input logic [W-1:0] v, input string req, input bit with_fs,
                           input int wr_at, input logic [W-1:0] wv,
                           input int clr_at, input int set_at, input int soft_at);
    for (int k = 0; k < W; k++) begin
      fs_i       = with_fs && (k == 0);
      wr_i       = (k == wr_at);
      wr_data_i  = wv;
      ctrl_wr_i  = (k == clr_at) || (k == set_at);
      ctrl_en_i  = (k == set_at);
      soft_rst_i = (k == soft_at);
      step();
      check(req, {31'd0, sd_oe_o}, 32'd1);
      check(req, {31'd0, sd_o}, {31'd0, v[W-1-k]});
      if (k == clr_at) check("R4", {31'd0, empty_o}, 32'd1);
    end
    fs_i = 1'b0; wr_i = 1'b0; ctrl_wr_i = 1'b0; ctrl_en_i = 1'b0; soft_rst_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    check("R8", {31'd0, sd_oe_o}, 32'd0);
    check("R8", {31'd0, empty_o}, 32'd1);
    check("R8", {31'd0, underrun_o}, 32'd0);
    rst_ni = 1'b1;
    step();
    check("R8", {31'd0, sd_oe_o}, 32'd0);

    // R1, R10: sweep every word value, one word per frame
    set_en(1'b1);
    for (int v = 0; v < (1 << W); v++) begin
      write_word(W'(v));
      word_bits(W'(v), "R1", 1'b1, -1, '0, -1, -1, -1);
      check("R9", {31'd0, empty_o}, 32'd1);
      step();
      check("R10", {31'd0, sd_oe_o}, 32'd0);
    end

    // R3, R4: write then clear mid-word; word finishes, held word discarded
    write_word(8'hA5);
    word_bits(8'hA5, "R3", 1'b1, 2, 8'h5A, 3, -1, -1);
    step();
    check("R3", {31'd0, sd_oe_o}, 32'd0);
    check("R4", {31'd0, empty_o}, 32'd1);

    // R6: frame starts disabled, pin follows flag_i one edge late
    flag_i = 1'b1; fs_i = 1'b1;
    step();
    fs_i = 1'b0;
    check("R6", {31'd0, sd_oe_o}, 32'd1);
    check("R6", {31'd0, sd_o}, 32'd1);
    // R2: enable set mid-frame changes nothing yet
    set_en(1'b1);
    check("R2", {31'd0, sd_oe_o}, 32'd1);
    check("R2", {31'd0, sd_o}, 32'd1);
    for (int i = 0; i < 6; i++) begin
      flag_i = i[0];
      step();
      check("R6", {31'd0, sd_o}, {31'd0, i[0]});
      check("R6", {31'd0, sd_oe_o}, 32'd1);
    end

    // R4, R9: discarded 5A never sent; last word A5 resent with underrun
    word_bits(8'hA5, "R4", 1'b1, -1, '0, -1, -1, -1);
    check("R9", {31'd0, underrun_o}, 32'd1);
    step();
    write_word(8'h3C);
    check("R9", {31'd0, underrun_o}, 32'd0);
    check("R9", {31'd0, empty_o}, 32'd0);
    word_bits(8'h3C, "R1", 1'b1, -1, '0, -1, -1, -1);
    step();

    // R5: write while disabled, no transfer
    set_en(1'b0);
    flag_i = 1'b0; fs_i = 1'b1;
    step();
    fs_i = 1'b0;
    write_word(8'hC3);
    check("R5", {31'd0, empty_o}, 32'd0);
    for (int i = 0; i < 4; i++) begin
      step();
      check("R5", {31'd0, sd_oe_o}, 32'd1);
      check("R5", {31'd0, sd_o}, 32'd0);
    end
    set_en(1'b1);
    word_bits(8'hC3, "R5", 1'b1, -1, '0, -1, -1, -1);
    step();

    // R7: network mode back-to-back, clear+set stops after the word
    net_mode_i = 1'b1;
    write_word(8'h11);
    word_bits(8'h11, "R7", 1'b1, 2, 8'h22, -1, -1, -1);
    word_bits(8'h22, "R7", 1'b0, 6, 8'h33, 3, 4, -1);
    for (int i = 0; i < 4; i++) begin
      step();
      check("R7", {31'd0, sd_oe_o}, 32'd0);
    end
    check("R7", {31'd0, empty_o}, 32'd0);
    word_bits(8'h33, "R7", 1'b1, -1, '0, -1, -1, -1);
    // R9 in network mode, then R8 soft reset mid-word
    word_bits(8'h33, "R9", 1'b0, -1, '0, -1, -1, 2);
    check("R9", {31'd0, underrun_o}, 32'd1);
    step();
    check("R8", {31'd0, sd_oe_o}, 32'd0);
    flag_i = 1'b1; fs_i = 1'b1;
    step();
    fs_i = 1'b0;
    check("R8", {31'd0, sd_oe_o}, 32'd1);
    check("R8", {31'd0, sd_o}, 32'd1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule